// File: doc/BRIEF.md
# Command Response Error Checker

This block sits beside the command-line logic of an SD host and watches the command line one bus clock at a time. While the host is sending a command, it compares each driven 1 with the value sampled on the next bus clock. If the line reads 0, another driver is fighting the host. The checker then raises an abort so the serializer releases the line, and it reports the clash as a CRC error and a timeout error together.

After the command's end bit, the serializer pulses a strobe. The checker then waits for the response start bit. If none arrives within a bounded window, it reports a timeout. When a response does arrive, the checker follows it bit by bit and checks three things: the CRC-7 over the response, the end bit, and optionally the echoed command index. Any failure is reported as a single-cycle pulse that a status register block can latch.

The pair (CRC error, timeout error) carries a fixed meaning. 00 means no fault. 01 means no response. 10 means a response arrived with a bad checksum. 11 means a line conflict.

Top module: `sd_cmd_errchk`

## Requirements
- R1: While reset is held and in the first cycle after its release, err_tmo, err_crc, err_end, err_idx and abort_drv are all 0.
- R2: Cycle 0 is the cycle in which cmd_done is high. If line_in stays 1 through cycles 1 to 64, err_tmo (pair value 01) pulses high for exactly one cycle, in cycle 65. A start bit (line_in 0) first seen in cycle 64 still counts as a response, and no timeout follows.
- R3: Suppose tx_en=1 and tx_bit=1 in cycle k, and line_in=0 in cycle k+1. Then err_crc and err_tmo (pair value 11) both pulse for one cycle in cycle k+2, and abort_drv rises in that same cycle. Driving a 0, or having tx_en low, followed by line_in 0 raises nothing.
- R4: Once raised, abort_drv stays high while tx_en is 1. It falls in the cycle after the first cycle in which tx_en is 0. A cmd_done that arrives while abort_drv is high starts no response wait, so no timeout follows it.
- R5: A short response is 48 bits, sent first bit first: start 0, direction, a 6-bit index (MSB first), a 32-bit argument, a 7-bit CRC, and an end bit. Its CRC-7 uses x^7+x^3+1 with a zero seed, computed over bits 0 to 39. A mismatch pulses err_crc alone (pair 10) in the cycle after the end bit.
- R6: An end bit of 0 pulses err_end for one cycle in the cycle after the end bit.
- R7: With idx_chk high, a short response whose index field differs from exp_idx pulses err_idx in the cycle after the end bit. With idx_chk low, no index error is raised.
- R8: A long response (rsp_long=1) is 136 bits: start, direction, 6 reserved bits, a 120-bit payload, a 7-bit CRC, and an end bit. Its CRC covers only the 120 payload bits. The reserved bits and idx_chk have no effect on its result.
- R9: A well-formed response raises no error pulse.
- R10: rsp_long, exp_idx and idx_chk are captured in the cmd_done cycle. Changing them during the wait or the reception has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit | input | 1 | Command bit the host drives this cycle |
| tx_en | input | 1 | Host drive enable on the command line |
| line_in | input | 1 | Sampled command line value |
| cmd_done | input | 1 | Strobe in the cycle of the command end bit |
| rsp_long | input | 1 | 1 selects a 136-bit response, 0 a 48-bit one |
| exp_idx | input | IDX_W | Expected response index |
| idx_chk | input | 1 | Enables the index comparison |
| err_tmo | output | 1 | Timeout error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_end | output | 1 | End-bit error pulse |
| err_idx | output | 1 | Index error pulse |
| abort_drv | output | 1 | Tells the serializer to stop driving |

## Verification
The bench targets the edges of the timeout window: a start bit in cycle 64 must be accepted, while silence through cycle 64 must give a timeout in cycle 65. An off-by-one counter would either time out a valid late response or miss the deadline by a cycle. Long responses use non-zero reserved bits together with a deliberately wrong index. A design that folded the header into the CRC, or checked the index on long frames, would flag errors on a correct frame.

The conflict tests separate a driven 1 from a driven 0 and from an idle host. They then hold tx_en after the abort and send a cmd_done during it. A design that only pulsed the abort, or that kept listening for a response, would either release the line early or report a false timeout. The capture test changes the index settings during reception, which exposes any comparison made against the live inputs.

// File: rtl/sd_cmdchk_pkg.sv
package sd_cmdchk_pkg;

  localparam int CRC_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } rsp_state_e;

  // one serial step of the x^7+x^3+1 register, message bit in at the top
  function automatic logic [CRC_W-1:0] crc7_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/cmdchk_conflict.sv
module cmdchk_conflict (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit,
  input  logic tx_en,
  input  logic line_in,
  output logic conflict_o,
  output logic abort_o
);

  logic drove_one_q;

  // a driven 1 last cycle that reads back as 0 now
  assign conflict_o = drove_one_q && !line_in && !abort_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drove_one_q <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      drove_one_q <= tx_en && tx_bit;
      if (conflict_o)
        abort_o <= 1'b1;
      else if (!tx_en)
        abort_o <= 1'b0;
    end
  end

endmodule

// File: rtl/cmdchk_rsp.sv
module cmdchk_rsp
  import sd_cmdchk_pkg::*;
#(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int LONG_HDR  = 8,
  parameter int TMO_CYC   = 64,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             kill_i,
  input  logic             line_in,
  input  logic             rsp_long,
  input  logic [IDX_W-1:0] exp_idx,
  input  logic             idx_chk,
  output logic             tmo_ev,
  output logic             crc_ev,
  output logic             end_ev,
  output logic             idx_ev
);

  localparam int POS_W = $clog2(LONG_LEN);
  localparam int CNT_W = $clog2(TMO_CYC);
  localparam logic [POS_W-1:0] S_LAST   = POS_W'(SHORT_LEN - 1);
  localparam logic [POS_W-1:0] L_LAST   = POS_W'(LONG_LEN - 1);
  localparam logic [POS_W-1:0] S_PAY_LO = POS_W'(1);
  localparam logic [POS_W-1:0] L_PAY_LO = POS_W'(LONG_HDR);
  localparam logic [POS_W-1:0] S_PAY_HI = POS_W'(SHORT_LEN - 2 - CRC_W);
  localparam logic [POS_W-1:0] L_PAY_HI = POS_W'(LONG_LEN - 2 - CRC_W);
  localparam logic [POS_W-1:0] IDX_LO   = POS_W'(2);
  localparam logic [POS_W-1:0] IDX_HI   = POS_W'(1 + IDX_W);
  localparam logic [CNT_W-1:0] W_LAST   = CNT_W'(TMO_CYC - 1);

  rsp_state_e       st;
  logic [CNT_W-1:0] wcnt;
  logic [POS_W-1:0] pos;
  logic [CRC_W-1:0] crc_acc, rx_crc;
  logic [IDX_W-1:0] rx_idx, idx_q;
  logic             long_q, chk_q;

  logic [POS_W-1:0] last_pos, pay_lo, pay_hi;
  logic             in_pay, in_crcf, in_idx;
  logic             wait_expire, frame_end;

  always_comb begin
    last_pos = long_q ? L_LAST : S_LAST;
    pay_lo   = long_q ? L_PAY_LO : S_PAY_LO;
    pay_hi   = long_q ? L_PAY_HI : S_PAY_HI;
    in_pay   = (pos >= pay_lo) && (pos <= pay_hi);
    in_crcf  = (pos > pay_hi) && (pos < last_pos);
    in_idx   = !long_q && (pos >= IDX_LO) && (pos <= IDX_HI);
  end

  assign wait_expire = (st == ST_WAIT) && line_in && (wcnt == W_LAST) && !kill_i;
  assign frame_end   = (st == ST_RECV) && (pos == last_pos) && !kill_i;

  assign tmo_ev = wait_expire;
  assign end_ev = frame_end && !line_in;
  assign crc_ev = frame_end && (crc_acc != rx_crc);
  assign idx_ev = frame_end && chk_q && !long_q && (rx_idx != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wcnt    <= '0;
      pos     <= '0;
      crc_acc <= '0;
      rx_crc  <= '0;
      rx_idx  <= '0;
      idx_q   <= '0;
      long_q  <= 1'b0;
      chk_q   <= 1'b0;
    end else if (kill_i) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            st     <= ST_WAIT;
            wcnt   <= '0;
            long_q <= rsp_long;
            idx_q  <= exp_idx;
            chk_q  <= idx_chk;
          end
        end
        ST_WAIT: begin
          if (!line_in) begin
            st      <= ST_RECV;
            pos     <= POS_W'(1);
            crc_acc <= '0;
          end else if (wcnt == W_LAST) begin
            st <= ST_IDLE;
          end else begin
            wcnt <= wcnt + CNT_W'(1);
          end
        end
        ST_RECV: begin
          if (in_pay)  crc_acc <= crc7_next(crc_acc, line_in);
          if (in_crcf) rx_crc  <= {rx_crc[CRC_W-2:0], line_in};
          if (in_idx)  rx_idx  <= {rx_idx[IDX_W-2:0], line_in};
          if (pos == last_pos) st  <= ST_IDLE;
          else                 pos <= pos + POS_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_errchk.sv
module sd_cmd_errchk #(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int LONG_HDR  = 8,
  parameter int TMO_CYC   = 64,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bit,
  input  logic             tx_en,
  input  logic             line_in,
  input  logic             cmd_done,
  input  logic             rsp_long,
  input  logic [IDX_W-1:0] exp_idx,
  input  logic             idx_chk,
  output logic             err_tmo,
  output logic             err_crc,
  output logic             err_end,
  output logic             err_idx,
  output logic             abort_drv
);

  logic conflict_w;
  logic tmo_ev, crc_ev, end_ev, idx_ev;
  logic rsp_start;

  cmdchk_conflict u_conflict (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_bit     (tx_bit),
    .tx_en      (tx_en),
    .line_in    (line_in),
    .conflict_o (conflict_w),
    .abort_o    (abort_drv)
  );

  assign rsp_start = cmd_done && !abort_drv && !conflict_w;

  cmdchk_rsp #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .LONG_HDR  (LONG_HDR),
    .TMO_CYC   (TMO_CYC),
    .IDX_W     (IDX_W)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (rsp_start),
    .kill_i   (conflict_w),
    .line_in  (line_in),
    .rsp_long (rsp_long),
    .exp_idx  (exp_idx),
    .idx_chk  (idx_chk),
    .tmo_ev   (tmo_ev),
    .crc_ev   (crc_ev),
    .end_ev   (end_ev),
    .idx_ev   (idx_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_tmo <= 1'b0;
      err_crc <= 1'b0;
      err_end <= 1'b0;
      err_idx <= 1'b0;
    end else begin
      err_tmo <= tmo_ev || conflict_w;
      err_crc <= crc_ev || conflict_w;
      err_end <= end_ev;
      err_idx <= idx_ev;
    end
  end

endmodule

// File: rtl/sd_cmd_errchk_sva.sv
module sd_cmd_errchk_sva (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic err_tmo,
  input logic err_crc,
  input logic err_end,
  input logic err_idx,
  input logic abort_drv
);

  p_pulse_tmo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |=> !err_tmo);

  p_conflict_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tmo && err_crc) |-> $rose(abort_drv));

  p_abort_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_drv) |-> (err_tmo && err_crc));

  p_abort_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_drv && tx_en) |=> abort_drv);

  p_abort_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_drv && !tx_en) |=> !abort_drv);

  p_pulse_crc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |=> !err_crc);

  p_end_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_end |-> !err_tmo);

  p_idx_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_idx |-> !err_tmo);

endmodule

bind sd_cmd_errchk sd_cmd_errchk_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .err_tmo   (err_tmo),
  .err_crc   (err_crc),
  .err_end   (err_end),
  .err_idx   (err_idx),
  .abort_drv (abort_drv)
);

// File: tb/sd_cmd_errchk_tb_top.sv
module sd_cmd_errchk_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b0, tx_en = 1'b0, line_in = 1'b1, cmd_done = 1'b0;
  logic       rsp_long = 1'b0, idx_chk = 1'b0;
  logic [5:0] exp_idx = '0;
  logic       err_tmo, err_crc, err_end, err_idx, abort_drv;

  int n_chk = 0, n_err = 0;
  int n_tmo, n_crc, n_end, n_idx;
  logic s_tmo, s_crc, s_end, s_idx, s_abort;

  always #10 clk = ~clk;

  sd_cmd_errchk dut_i (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_en(tx_en), .line_in(line_in),
    .cmd_done(cmd_done), .rsp_long(rsp_long), .exp_idx(exp_idx), .idx_chk(idx_chk),
    .err_tmo(err_tmo), .err_crc(err_crc), .err_end(err_end), .err_idx(err_idx),
    .abort_drv(abort_drv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_tmo = 0; n_crc = 0; n_end = 0; n_idx = 0;
  endtask

  // drive one bus cycle, then sample what the design registered from it
  task automatic step(input logic ln);
    line_in = ln;
    @(negedge clk);
    s_tmo = err_tmo; s_crc = err_crc; s_end = err_end; s_idx = err_idx; s_abort = abort_drv;
    n_tmo += int'(s_tmo); n_crc += int'(s_crc); n_end += int'(s_end); n_idx += int'(s_idx);
  endtask

  // augmented long division by x^7+x^3+1
  function automatic logic [6:0] crc_ref(input logic [127:0] m, input int n);
    logic [6:0] rem = '0;
    logic [7:0] r8;
    for (int i = n - 1; i >= -7; i--) begin
      r8 = {rem, (i >= 0) ? m[i] : 1'b0};
      if (r8[7]) r8 ^= 8'h89;
      rem = r8[6:0];
    end
    return rem;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg,
                                             input bit bad_crc, input bit bad_end);
    logic [39:0] m;
    logic [6:0]  c;
    m = {2'b00, idx, arg};
    c = crc_ref({88'b0, m}, 40);
    if (bad_crc) c ^= 7'h10;
    return {88'b0, m, c, ~bad_end};
  endfunction

  function automatic logic [135:0] mk_long(input logic [5:0] rsv, input logic [119:0] pay,
                                            input bit bad_crc);
    logic [6:0] c;
    c = crc_ref({8'b0, pay}, 120);
    if (bad_crc) c ^= 7'h01;
    return {2'b00, rsv, pay, c, 1'b1};
  endfunction

  task automatic issue(input logic lng, input logic [5:0] idx, input logic chk_en);
    clr();
    rsp_long = lng; exp_idx = idx; idx_chk = chk_en; cmd_done = 1'b1;
    step(1'b1);
    cmd_done = 1'b0;
    step(1'b1);
    step(1'b1);
  endtask

  task automatic send(input logic [135:0] v, input int len);
    for (int p = 0; p < len; p++) step(v[len-1-p]);
  endtask

  task automatic expect_end(input string tag, input int t, input int c, input int e, input int x);
    chk({tag, " tmo at end"}, int'(s_tmo), t);
    chk({tag, " crc at end"}, int'(s_crc), c);
    chk({tag, " end at end"}, int'(s_end), e);
    chk({tag, " idx at end"}, int'(s_idx), x);
    step(1'b1); step(1'b1);
    chk({tag, " total pulses"}, n_tmo + n_crc + n_end + n_idx, t + c + e + x);
  endtask

  task automatic t_reset();
    chk("R1 tmo in reset", int'(err_tmo), 0);
    chk("R1 crc in reset", int'(err_crc), 0);
    chk("R1 abort in reset", int'(abort_drv), 0);
    @(negedge clk); rst_n = 1'b1;
    clr(); step(1'b1);
    chk("R1 outputs after release", int'({s_tmo, s_crc, s_end, s_idx, s_abort}), 0);
  endtask

  task automatic t_good_short();
    issue(1'b0, 6'd17, 1'b1);
    send(mk_short(6'd17, 32'h1234_5678, 0, 0), 48);
    expect_end("R9 short clean", 0, 0, 0, 0);
  endtask

  task automatic t_crc_short();
    issue(1'b0, 6'd3, 1'b1);
    send(mk_short(6'd3, 32'hDEAD_BEEF, 1, 0), 48);
    expect_end("R5 short crc", 0, 1, 0, 0);
  endtask

  task automatic t_endbit();
    issue(1'b0, 6'd8, 1'b0);
    send(mk_short(6'd8, 32'h0000_00FF, 0, 1), 48);
    expect_end("R6 end bit", 0, 0, 1, 0);
  endtask

  task automatic t_index();
    issue(1'b0, 6'd17, 1'b1);
    send(mk_short(6'd18, 32'hA5A5_0F0F, 0, 0), 48);
    expect_end("R7 idx mismatch", 0, 0, 0, 1);
    issue(1'b0, 6'd17, 1'b0);
    send(mk_short(6'd18, 32'hA5A5_0F0F, 0, 0), 48);
    expect_end("R7 idx disabled", 0, 0, 0, 0);
  endtask

  task automatic t_long();
    logic [119:0] pay = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    issue(1'b1, 6'd2, 1'b1);
    send(mk_long(6'b101010, pay, 0), 136);
    expect_end("R8 long clean", 0, 0, 0, 0);
    issue(1'b1, 6'd2, 1'b0);
    send(mk_long(6'b111111, pay, 1), 136);
    expect_end("R8 long crc", 0, 1, 0, 0);
  endtask

  task automatic t_capture();
    issue(1'b0, 6'd5, 1'b1);
    exp_idx = 6'd9; idx_chk = 1'b1; rsp_long = 1'b1;
    send(mk_short(6'd5, 32'h0F0F_1234, 0, 0), 48);
    expect_end("R10 settings captured", 0, 0, 0, 0);
    rsp_long = 1'b0;
  endtask

  task automatic t_timeout();
    issue(1'b0, 6'd1, 1'b0);
    // issue consumed cycles 0..2
    for (int c = 3; c <= 63; c++) step(1'b1);
    chk("R2 no tmo through cycle 63", n_tmo, 0);
    step(1'b1);
    chk("R2 tmo in cycle 65", int'(s_tmo), 1);
    chk("R2 crc stays low", int'(s_crc), 0);
    step(1'b1); step(1'b1);
    chk("R2 single tmo pulse", n_tmo, 1);
    // start bit exactly in cycle 64
    issue(1'b0, 6'd1, 1'b0);
    for (int c = 3; c <= 63; c++) step(1'b1);
    send(mk_short(6'd1, 32'h5555_AAAA, 0, 0), 48);
    expect_end("R2 late start accepted", 0, 0, 0, 0);
  endtask

  task automatic t_conflict();
    clr();
    tx_en = 1'b1; tx_bit = 1'b0; step(1'b0);
    step(1'b0);
    chk("R3 driven zero no error", n_tmo + n_crc + int'(s_abort), 0);
    tx_en = 1'b0; tx_bit = 1'b1; step(1'b0);
    step(1'b0);
    chk("R3 idle host no error", n_tmo + n_crc + int'(s_abort), 0);
    tx_en = 1'b1; tx_bit = 1'b1; step(1'b1);
    chk("R3 nothing before clash", int'(s_tmo || s_crc || s_abort), 0);
    step(1'b0);
    chk("R3 tmo on clash", int'(s_tmo), 1);
    chk("R3 crc on clash", int'(s_crc), 1);
    chk("R3 abort on clash", int'(s_abort), 1);
    cmd_done = 1'b1; step(1'b0); cmd_done = 1'b0;
    chk("R3 pair is one cycle", int'(s_tmo || s_crc), 0);
    step(1'b1); step(1'b1);
    chk("R4 abort held while driving", int'(s_abort), 1);
    tx_en = 1'b0; tx_bit = 1'b0; step(1'b1);
    chk("R4 abort released", int'(s_abort), 0);
    clr();
    for (int c = 0; c < 70; c++) step(1'b1);
    chk("R4 cmd_done in abort ignored", n_tmo, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_good_short();
    t_crc_short();
    t_endbit();
    t_index();
    t_long();
    t_capture();
    t_timeout();
    t_conflict();
    finish_run();
  end

endmodule